// File: doc/BRIEF.md
# Register-Mapped Serial Byte Port

This block places a byte-oriented serial transmitter/receiver pair behind a small AXI-Lite slave. Bus masters see two 32-bit registers. A data register sits at offset 0x00 and a read-only status register at offset 0x04. The serial engine itself, with its bit timing and byte FIFOs, lives outside the block. It is reached only through a ready/valid transmit byte port, a ready/valid receive byte port and two activity flags.

Writing the data register hands the low byte of the write data to the transmit port. Reading the data register takes the oldest received byte and removes it from the receive side. Software polls the status register to learn whether there is room to send, whether a byte is waiting, and whether either serial direction is mid-frame.

Each incoming address and write-data channel passes through a one-entry register stage. Because of this, no READY output depends on the same cycle's VALID. A single commit condition completes a write. The same condition both answers the bus and strobes the byte into the transmitter.

Top module: `serial_regport`

## Requirements
- R1: A write whose address bit 2 is 0 (data register) produces exactly one cycle of `tx_byte_valid` with `tx_byte` equal to write data bits [7:0].
- R2: A write completes only in a cycle where a buffered address and buffered write data are both present, no write response is pending, and `tx_byte_ready` is 1. `tx_byte_valid` is never high while `tx_byte_ready` is low. While `tx_byte_ready` stays low, no write response appears.
- R3: `bus_awready`, `bus_wready` and `bus_arready` are 1 exactly when their one-entry stage is empty, whatever VALID does in that cycle. A stage whose request is stalled keeps its READY low.
- R4: `bus_bvalid` rises in the cycle after a write completes, with `bus_bresp` = 2'b00. It stays high until a cycle with `bus_bready` high.
- R5: A read whose address bit 2 is 0 returns `rx_byte` in `bus_rdata[7:0]` with bits [31:8] zero. It raises `rx_byte_ready` for exactly the one cycle in which the read is accepted.
- R6: A data-register read while `rx_byte_valid` is 0 returns 0 and leaves `rx_byte_ready` low.
- R7: A read whose address bit 2 is 1 (status register) returns bit 0 = `tx_byte_ready`, bit 1 = `rx_byte_valid`, bit 2 = `tx_active`, bit 3 = `rx_active`, and zeros in bits [31:4]. These values are sampled in the cycle the read is accepted.
- R8: A write whose address bit 2 is 1 receives an OKAY response and raises no `tx_byte_valid`.
- R9: `bus_rvalid` stays high with stable `bus_rdata` and `bus_rresp` = 2'b00 until `bus_rready` is seen. No new read is accepted while a read response is pending.
- R10: Bytes written to the data register and looped back from transmitter to receiver are read back in write order. Once all of them are read, status bit 1 reads 0.
- R11: After reset all three READY outputs are 1, and `bus_bvalid`, `bus_rvalid`, `tx_byte_valid` and `rx_byte_ready` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_awaddr | input | ADDR_W | Write address |
| bus_awvalid | input | 1 | Write address valid |
| bus_awready | output | 1 | Write address stage empty |
| bus_wdata | input | DATA_W | Write data |
| bus_wvalid | input | 1 | Write data valid |
| bus_wready | output | 1 | Write data stage empty |
| bus_bresp | output | 2 | Write response, always OKAY |
| bus_bvalid | output | 1 | Write response valid |
| bus_bready | input | 1 | Write response accepted |
| bus_araddr | input | ADDR_W | Read address |
| bus_arvalid | input | 1 | Read address valid |
| bus_arready | output | 1 | Read address stage empty |
| bus_rdata | output | DATA_W | Read data |
| bus_rresp | output | 2 | Read response, always OKAY |
| bus_rvalid | output | 1 | Read response valid |
| bus_rready | input | 1 | Read response accepted |
| tx_byte | output | 8 | Byte toward the transmitter |
| tx_byte_valid | output | 1 | Enqueue strobe toward the transmitter |
| tx_byte_ready | input | 1 | Transmitter can take a byte |
| rx_byte | input | 8 | Oldest received byte |
| rx_byte_valid | input | 1 | A received byte is waiting |
| rx_byte_ready | output | 1 | Dequeue strobe toward the receiver |
| tx_active | input | 1 | Transmitter is shifting a frame |
| rx_active | input | 1 | Receiver is sampling a frame |

## Verification
The properties assume that the serial side behaves like a FIFO. That means `rx_byte` is the byte removed on a dequeue strobe, and `tx_byte_ready` and `rx_byte_valid` only change between clock edges, never in response to the strobes within a cycle. The bus master is assumed to hold each VALID until its handshake. The stimulus keeps to these assumptions in the following way. A bench-side serial stub drives its flags from queues, updated once per cycle, and feeds transmitted bytes back into its receive queue after a fixed delay. The bus tasks lower each VALID only after the handshake they observed.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;

    localparam int BYTE_W  = 8;
    localparam int SEL_BIT = 2;
    localparam logic [1:0] RESP_OKAY = 2'b00;

    typedef enum logic {
        REG_DATA   = 1'b0,
        REG_STATUS = 1'b1
    } reg_sel_e;

    // first member lands in the most significant bit
    typedef struct packed {
        logic rx_active;
        logic tx_active;
        logic rx_pending;
        logic tx_room;
    } status_t;

    localparam int STATUS_W = $bits(status_t);

    function automatic reg_sel_e decode_sel(input logic sel_bit);
        return sel_bit ? REG_STATUS : REG_DATA;
    endfunction

endpackage

// File: rtl/serial_regport_slice.sv
module serial_regport_slice #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic [W-1:0] out_data
);

    logic         full_q;
    logic [W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q <= 1'b0;
            data_q <= '0;
        end else if (in_valid && !full_q) begin
            full_q <= 1'b1;
            data_q <= in_data;
        end else if (out_ready && full_q) begin
            full_q <= 1'b0;
        end
    end

    assign in_ready  = !full_q;
    assign out_valid = full_q;
    assign out_data  = data_q;

endmodule

// File: rtl/serial_regport_wr.sv
module serial_regport_wr
    import serial_regport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              addr_valid,
    input  logic              addr_sel,
    output logic              addr_pop,
    input  logic              data_valid,
    input  logic [BYTE_W-1:0] data_byte,
    output logic              data_pop,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              bready,
    output logic              bvalid,
    output logic [1:0]        bresp
);

    logic b_pend_q;
    logic commit;

    // one condition answers the bus and strobes the transmitter
    assign commit   = addr_valid && data_valid && !b_pend_q && tx_ready;
    assign addr_pop = commit;
    assign data_pop = commit;
    assign tx_valid = commit && (decode_sel(addr_sel) == REG_DATA);
    assign tx_data  = data_byte;

    always_ff @(posedge clk) begin
        if (rst) begin
            b_pend_q <= 1'b0;
        end else if (commit) begin
            b_pend_q <= 1'b1;
        end else if (b_pend_q && bready) begin
            b_pend_q <= 1'b0;
        end
    end

    assign bvalid = b_pend_q;
    assign bresp  = RESP_OKAY;

endmodule

// File: rtl/serial_regport_rd.sv
module serial_regport_rd
    import serial_regport_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_sel,
    output logic              req_pop,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    input  status_t           stat,
    input  logic              rready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic [1:0]        rresp
);

    localparam int PAD_BYTE = DATA_W - BYTE_W;
    localparam int PAD_STAT = DATA_W - STATUS_W;

    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rdata_d;
    logic              accept;
    reg_sel_e          sel;

    assign sel      = decode_sel(req_sel);
    assign accept   = req_valid && !rvalid_q;
    assign req_pop  = accept;
    assign rx_ready = accept && (sel == REG_DATA) && rx_valid;

    always_comb begin
        if (sel == REG_STATUS) begin
            rdata_d = {{PAD_STAT{1'b0}}, stat};
        end else if (rx_valid) begin
            rdata_d = {{PAD_BYTE{1'b0}}, rx_data};
        end else begin
            rdata_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (accept) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rdata_d;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

    assign rvalid = rvalid_q;
    assign rdata  = rdata_q;
    assign rresp  = RESP_OKAY;

endmodule

// File: rtl/serial_regport.sv
module serial_regport
    import serial_regport_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_awaddr,
    input  logic              bus_awvalid,
    output logic              bus_awready,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_wvalid,
    output logic              bus_wready,
    output logic [1:0]        bus_bresp,
    output logic              bus_bvalid,
    input  logic              bus_bready,
    input  logic [ADDR_W-1:0] bus_araddr,
    input  logic              bus_arvalid,
    output logic              bus_arready,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [1:0]        bus_rresp,
    output logic              bus_rvalid,
    input  logic              bus_rready,
    output logic [7:0]        tx_byte,
    output logic              tx_byte_valid,
    input  logic              tx_byte_ready,
    input  logic [7:0]        rx_byte,
    input  logic              rx_byte_valid,
    output logic              rx_byte_ready,
    input  logic              tx_active,
    input  logic              rx_active
);

    logic              aw_v, aw_sel, aw_pop;
    logic              w_v, w_pop;
    logic [BYTE_W-1:0] w_byte;
    logic              ar_v, ar_sel, ar_pop;
    status_t           stat;

    // only the select bit and the low data byte carry meaning
    logic unused_bits;
    assign unused_bits = ^{bus_awaddr[ADDR_W-1:SEL_BIT+1], bus_awaddr[SEL_BIT-1:0],
                           bus_araddr[ADDR_W-1:SEL_BIT+1], bus_araddr[SEL_BIT-1:0],
                           bus_wdata[DATA_W-1:BYTE_W]};

    serial_regport_slice #(.W(1)) u_aw_stage (
        .clk(clk), .rst(rst),
        .in_valid(bus_awvalid), .in_ready(bus_awready), .in_data(bus_awaddr[SEL_BIT]),
        .out_valid(aw_v), .out_ready(aw_pop), .out_data(aw_sel)
    );

    serial_regport_slice #(.W(BYTE_W)) u_w_stage (
        .clk(clk), .rst(rst),
        .in_valid(bus_wvalid), .in_ready(bus_wready), .in_data(bus_wdata[BYTE_W-1:0]),
        .out_valid(w_v), .out_ready(w_pop), .out_data(w_byte)
    );

    serial_regport_slice #(.W(1)) u_ar_stage (
        .clk(clk), .rst(rst),
        .in_valid(bus_arvalid), .in_ready(bus_arready), .in_data(bus_araddr[SEL_BIT]),
        .out_valid(ar_v), .out_ready(ar_pop), .out_data(ar_sel)
    );

    serial_regport_wr u_wr (
        .clk(clk), .rst(rst),
        .addr_valid(aw_v), .addr_sel(aw_sel), .addr_pop(aw_pop),
        .data_valid(w_v), .data_byte(w_byte), .data_pop(w_pop),
        .tx_ready(tx_byte_ready), .tx_valid(tx_byte_valid), .tx_data(tx_byte),
        .bready(bus_bready), .bvalid(bus_bvalid), .bresp(bus_bresp)
    );

    assign stat = '{rx_active: rx_active, tx_active: tx_active,
                    rx_pending: rx_byte_valid, tx_room: tx_byte_ready};

    serial_regport_rd #(.DATA_W(DATA_W)) u_rd (
        .clk(clk), .rst(rst),
        .req_valid(ar_v), .req_sel(ar_sel), .req_pop(ar_pop),
        .rx_valid(rx_byte_valid), .rx_data(rx_byte), .rx_ready(rx_byte_ready),
        .stat(stat),
        .rready(bus_rready), .rvalid(bus_rvalid), .rdata(bus_rdata), .rresp(bus_rresp)
    );

endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_bvalid,
    input logic              bus_bready,
    input logic [1:0]        bus_bresp,
    input logic              bus_rvalid,
    input logic              bus_rready,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              tx_byte_valid,
    input logic              tx_byte_ready,
    input logic [7:0]        rx_byte,
    input logic              rx_byte_valid,
    input logic              rx_byte_ready
);

    assert_tx_needs_ready_R2: assert property (@(posedge clk) disable iff (rst)
        tx_byte_valid |-> tx_byte_ready);

    assert_tx_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        tx_byte_valid |=> !tx_byte_valid);

    assert_tx_then_resp_R4: assert property (@(posedge clk) disable iff (rst)
        tx_byte_valid |=> (bus_bvalid && bus_bresp == 2'b00));

    assert_b_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_bvalid && !bus_bready) |=> bus_bvalid);

    assert_pop_needs_byte_R6: assert property (@(posedge clk) disable iff (rst)
        rx_byte_ready |-> rx_byte_valid);

    assert_pop_one_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        rx_byte_ready |=> !rx_byte_ready);

    assert_pop_returns_byte_R5: assert property (@(posedge clk) disable iff (rst)
        rx_byte_ready |=> (bus_rvalid && bus_rdata[7:0] == $past(rx_byte)
                           && bus_rdata[DATA_W-1:8] == '0));

    assert_r_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && !bus_rready) |=> (bus_rvalid && $stable(bus_rdata)));

    assert_no_pop_while_pending_R9: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> !rx_byte_ready);

endmodule

bind serial_regport serial_regport_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst),
    .bus_bvalid(bus_bvalid), .bus_bready(bus_bready), .bus_bresp(bus_bresp),
    .bus_rvalid(bus_rvalid), .bus_rready(bus_rready), .bus_rdata(bus_rdata),
    .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready),
    .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_byte_ready(rx_byte_ready)
);

// File: tb/serial_regport_test.sv
`timescale 1ns/1ps
module serial_regport_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  awaddr = '0, araddr = '0;
    logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
    logic [31:0] wdata = '0;
    logic        awready, wready, bvalid, arready, rvalid;
    logic [1:0]  bresp, rresp;
    logic [31:0] rdata;
    logic [7:0]  tx_byte, rx_byte = '0;
    logic        tx_byte_valid, rx_byte_ready;
    logic        tx_byte_ready = 1'b1, rx_byte_valid = 1'b0;
    logic        tx_active = 1'b0, rx_active = 1'b0;

    always #2.5 clk = ~clk;

    serial_regport uut (
        .clk(clk), .rst(rst),
        .bus_awaddr(awaddr), .bus_awvalid(awvalid), .bus_awready(awready),
        .bus_wdata(wdata), .bus_wvalid(wvalid), .bus_wready(wready),
        .bus_bresp(bresp), .bus_bvalid(bvalid), .bus_bready(bready),
        .bus_araddr(araddr), .bus_arvalid(arvalid), .bus_arready(arready),
        .bus_rdata(rdata), .bus_rresp(rresp), .bus_rvalid(rvalid), .bus_rready(rready),
        .tx_byte(tx_byte), .tx_byte_valid(tx_byte_valid), .tx_byte_ready(tx_byte_ready),
        .rx_byte(rx_byte), .rx_byte_valid(rx_byte_valid), .rx_byte_ready(rx_byte_ready),
        .tx_active(tx_active), .rx_active(rx_active)
    );

    int n_vec = 0, n_bad = 0, cyc = 0, n_pops = 0;
    int last_bhigh = 0, last_rhigh = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: got 0x%0h expected 0x%0h", req, cyc, act, exp);
        end
    endtask

    // serial stub: transmitted bytes reappear on the receive side after a delay
    logic [7:0] txlog[$];
    logic [7:0] rxq[$];
    logic [7:0] dq_byte[$];
    int         dq_due[$];

    always @(posedge clk) begin
        #1;
        rx_byte_valid = (rxq.size() != 0);
        rx_byte       = (rxq.size() != 0) ? rxq[0] : 8'h00;
    end

    // behavioural reference: one-deep stages, pending response flags
    bit         m_aw, m_w, m_ar, m_b, m_r;
    bit         m_aw_sel, m_ar_sel;
    logic [7:0] m_wbyte;
    logic [31:0] m_rdata;

    always @(negedge clk) begin
        bit wfire, rfire, p_txv, p_rxr;
        cyc++;
        if (cyc > 150000) begin
            chk(1'b0, "watchdog", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
        if (rst) begin
            m_aw = 0; m_w = 0; m_ar = 0; m_b = 0; m_r = 0;
        end else begin
            wfire = m_aw && m_w && !m_b && tx_byte_ready;
            rfire = m_ar && !m_r;
            p_txv = wfire && !m_aw_sel;
            p_rxr = rfire && !m_ar_sel && rx_byte_valid;
            chk(awready == !m_aw, "R3 awready", awready, !m_aw);
            chk(wready  == !m_w,  "R3 wready",  wready,  !m_w);
            chk(arready == !m_ar, "R3 arready", arready, !m_ar);
            chk(bvalid == m_b, "R4 bvalid", bvalid, m_b);
            chk(bresp == 2'b00, "R4 bresp", bresp, 0);
            chk(rvalid == m_r, "R9 rvalid", rvalid, m_r);
            chk(rresp == 2'b00, "R9 rresp", rresp, 0);
            if (m_r) chk(rdata == m_rdata, "R9 rdata", rdata, m_rdata);
            chk(tx_byte_valid == p_txv, "R2 tx_byte_valid", tx_byte_valid, p_txv);
            if (p_txv) chk(tx_byte == m_wbyte, "R1 tx_byte", tx_byte, m_wbyte);
            chk(rx_byte_ready == p_rxr, "R5 rx_byte_ready", rx_byte_ready, p_rxr);
            // advance reference
            if (!m_aw && awvalid) begin m_aw = 1; m_aw_sel = awaddr[2]; end
            else if (m_aw && wfire) m_aw = 0;
            if (!m_w && wvalid) begin m_w = 1; m_wbyte = wdata[7:0]; end
            else if (m_w && wfire) m_w = 0;
            if (rfire) begin
                m_r = 1;
                if (m_ar_sel) m_rdata = {28'h0, rx_active, tx_active, rx_byte_valid, tx_byte_ready};
                else m_rdata = rx_byte_valid ? {24'h0, rx_byte} : 32'h0;
            end else if (m_r && rready) m_r = 0;
            if (!m_ar && arvalid) begin m_ar = 1; m_ar_sel = araddr[2]; end
            else if (m_ar && rfire) m_ar = 0;
            if (wfire) m_b = 1;
            else if (m_b && bready) m_b = 0;
            // stub queues
            if (tx_byte_valid && tx_byte_ready) begin
                txlog.push_back(tx_byte);
                dq_byte.push_back(tx_byte);
                dq_due.push_back(cyc + 20);
            end
            if (rx_byte_ready && rx_byte_valid) begin
                void'(rxq.pop_front());
                n_pops++;
            end
            if (dq_due.size() != 0 && dq_due[0] <= cyc) begin
                rxq.push_back(dq_byte.pop_front());
                void'(dq_due.pop_front());
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d, input int bwait);
        bit aw_ok, w_ok, b_ok;
        int bhigh;
        aw_ok = 0; w_ok = 0; b_ok = 0; bhigh = 0;
        @(posedge clk); #1;
        awaddr = a; awvalid = 1; wdata = d; wvalid = 1; bready = (bwait == 0);
        while (!b_ok) begin
            @(negedge clk);
            if (awvalid && awready) aw_ok = 1;
            if (wvalid && wready) w_ok = 1;
            if (bvalid) begin
                if (bready) b_ok = 1; else bhigh++;
            end
            @(posedge clk); #1;
            if (aw_ok) awvalid = 0;
            if (w_ok) wvalid = 0;
            bready = (bhigh >= bwait) && !b_ok;
        end
        last_bhigh = bhigh;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d, input int rwait);
        bit ar_ok, r_ok;
        int rhigh;
        ar_ok = 0; r_ok = 0; rhigh = 0; d = '0;
        @(posedge clk); #1;
        araddr = a; arvalid = 1; rready = (rwait == 0);
        while (!r_ok) begin
            @(negedge clk);
            if (arvalid && arready) ar_ok = 1;
            if (rvalid) begin
                if (rready) begin r_ok = 1; d = rdata; end else rhigh++;
            end
            @(posedge clk); #1;
            if (ar_ok) arvalid = 0;
            rready = (rhigh >= rwait) && !r_ok;
        end
        last_rhigh = rhigh;
    endtask

    initial begin
        logic [31:0] d;
        logic [7:0]  exp_q[$];
        int          n, p0, polls;
        bit          wr_done;

        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk(awready && wready && arready, "R11 readies", {awready, wready, arready}, 3'b111);
        chk(!bvalid && !rvalid, "R11 response valids", {bvalid, rvalid}, 0);
        chk(!tx_byte_valid && !rx_byte_ready, "R11 strobes", {tx_byte_valid, rx_byte_ready}, 0);

        // two bytes, loopback, poll, read back
        bus_write(8'h00, 32'hFFFF_FF55, 0);
        bus_write(8'h00, 32'h0000_00A3, 0);
        chk(txlog.size() == 2, "R1 bytes sent", txlog.size(), 2);
        chk(txlog[0] == 8'h55 && txlog[1] == 8'hA3, "R1 sent values", {txlog[0], txlog[1]}, 16'h55A3);
        polls = 0;
        do begin bus_read(8'h04, d, 0); polls++; end while (!d[1] && polls < 200);
        chk(d[1], "R7 rx pending bit", d, 2);
        repeat (40) @(posedge clk);
        bus_read(8'h00, d, 0);
        chk(d == 32'h55, "R10 first byte", d, 32'h55);
        bus_read(8'h00, d, 0);
        chk(d == 32'hA3, "R10 second byte", d, 32'hA3);
        bus_read(8'h04, d, 0);
        chk(d[1] == 1'b0, "R10 drained", d, 1);

        // empty data read
        p0 = n_pops;
        bus_read(8'h00, d, 0);
        chk(d == 32'h0, "R6 empty read value", d, 0);
        chk(n_pops == p0, "R6 no dequeue", n_pops, p0);

        // status encoding
        @(posedge clk); #1 tx_byte_ready = 0; tx_active = 1; rx_active = 1;
        bus_read(8'h04, d, 0);
        chk(d == 32'hC, "R7 status busy/full", d, 32'hC);
        @(posedge clk); #1 tx_byte_ready = 1; tx_active = 0; rx_active = 1;
        bus_read(8'h0C, d, 0);
        chk(d == 32'h9, "R7 status room/rx busy", d, 32'h9);
        @(posedge clk); #1 rx_active = 0;

        // status write has no effect
        n = txlog.size();
        bus_write(8'h04, 32'h0000_00FF, 0);
        repeat (5) @(posedge clk);
        chk(txlog.size() == n, "R8 no enqueue", txlog.size(), n);
        bus_read(8'h04, d, 0);
        chk(d == 32'h1, "R8 status unchanged", d, 32'h1);

        // held responses
        bus_write(8'h04, 32'h0, 5);
        chk(last_bhigh == 5, "R4 bvalid held", last_bhigh, 5);
        bus_read(8'h04, d, 4);
        chk(d == 32'h1 && last_rhigh == 4, "R9 rvalid held", d, 32'h1);

        // transmitter back-pressure
        @(posedge clk); #1 tx_byte_ready = 0;
        n = txlog.size();
        wr_done = 0;
        fork
            begin bus_write(8'h00, 32'h3C, 0); wr_done = 1; end
        join_none
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk(!bvalid, "R2 no response while stalled", bvalid, 0);
        chk(txlog.size() == n, "R2 no enqueue while stalled", txlog.size(), n);
        chk(!awready && !wready, "R3 stages held full", {awready, wready}, 0);
        @(posedge clk); #1 tx_byte_ready = 1;
        wait (wr_done);
        chk(txlog.size() == n + 1 && txlog[n] == 8'h3C, "R1 stalled byte sent", txlog[txlog.size()-1], 8'h3C);

        // burst then ordered read-back
        exp_q = '{8'h3C, 8'h01, 8'h80, 8'hFE, 8'h7F};
        bus_write(8'h00, 32'h01, 0);
        bus_write(8'h10, 32'h80, 0);
        bus_write(8'h00, 32'hFE, 0);
        bus_write(8'h00, 32'h7F, 0);
        repeat (60) @(posedge clk);
        bus_read(8'h04, d, 0);
        chk(d == 32'h3, "R7 room and pending", d, 32'h3);
        foreach (exp_q[i]) begin
            bus_read(8'h00, d, (i == 2) ? 2 : 0);
            chk(d == {24'h0, exp_q[i]}, "R10 burst order", d, exp_q[i]);
        end
        bus_read(8'h04, d, 0);
        chk(d[1] == 1'b0, "R10 burst drained", d, 0);

        repeat (5) @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule